// File: doc/BRIEF.md
# Secure Branch-Exchange Resolve Unit

This unit sits in the execute stage of a 16-bit instruction pipeline. It looks at the branch-and-exchange halfword and resolves the branch variant that can leave the secure world. The instruction halfword, the target register value, the current security state and a user-only indication arrive together with a valid strobe.

One clock later the unit presents four results:
- the program counter to load;
- the instruction-set state bit;
- a single-cycle undefined-instruction flag;
- a request for one of two actions: an exception return, or a security-state switch with its target state.

The switch request feeds the stack-pointer switch unit.

Targets at or above a magic boundary are exception-return values, not branch addresses. For every other target, bit 0 names the destination security state. The unit does not fetch, read registers or process the exception return itself.

Top module: `sbx_resolve`

## Requirements
- R1: An instruction is in branch-exchange form when bits 15:8 equal 0x47. Bit 7 is the link flag, bits 6:3 name the register and bit 2 marks the non-secure variant. An instruction outside this form raises no flag and leaves the program counter, state bit and switch target unchanged. So does a plain form with bits 2:0 all zero.
- R2: A branch-exchange form with bit 0 or bit 1 set raises the undefined flag.
- R3: The non-secure variant (bit 2 set) raises the undefined flag in four cases: the security extension is absent, the core is not secure, user-only operation is indicated, or the link flag is set.
- R4: While the undefined flag is high, the program counter, state bit and switch target keep their previous values.
- R5: A legal non-secure variant whose target is 0xFF000000 or above has three effects. The program counter takes the target with bit 0 cleared, the state bit takes target bit 0, and the exception-return request pulses.
- R6: A legal non-secure variant with any lower target has four effects. The switch request pulses and the switch target takes target bit 0 (1 = secure, 0 = non-secure). The state bit becomes 1, and the program counter takes the target with bit 0 cleared.
- R7: The conditional-execution clear pulse is high exactly when a legal non-secure variant executes.
- R8: The output-valid pulse and all results appear on the clock edge after the valid strobe. Without a strobe, every pulse output is low on the next cycle.
- R9: The undefined, exception-return and switch outputs are never high together.
- R10: After reset, the program counter, state bit and switch target are 0, and all pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction strobe |
| insn | input | 16 | Instruction halfword |
| target | input | 32 | Value of the target register |
| cur_secure | input | 1 | Core is currently in the secure state |
| user_only | input | 1 | User-only operation |
| out_valid | output | 1 | Results valid pulse |
| new_pc | output | 32 | Program counter to load |
| isa_bit | output | 1 | Instruction-set state bit |
| undef_flag | output | 1 | Undefined-instruction pulse |
| excret_req | output | 1 | Exception-return request pulse |
| sw_req | output | 1 | Security-switch request pulse |
| sw_secure | output | 1 | Destination security state of the switch |
| cond_clr | output | 1 | Clear conditional-execution state pulse |

## Verification
The bench targets the magic boundary on both sides, 0xFF000000 and 0xFEFFFFFF. A comparator one bit off would turn a switch into an exception return, or the other way round. Undefined cases with targets that differ from earlier ones expose a design that loads the program counter anyway. The linking, non-secure-state and user-only variants catch a decoder that misses one condition. Plain and foreign opcodes catch a unit that acts on instructions it should ignore. Targets with bit 0 both set and clear check that the state bit is forced on the switch path but copied on the return path.

// File: rtl/sbx_pkg.sv
package sbx_pkg;
    localparam int ADDR_W = 32;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] pc;
        logic              isa;
        logic              undef;
        logic              excret;
        logic              sw;
        logic              sw_sec;
        logic              cclr;
    } sbx_state_t;
endpackage

// File: rtl/sbx_decode.sv
module sbx_decode #(
    parameter bit SEC_EXT = 1'b1
) (
    input  logic        in_valid,
    input  logic [15:0] insn,
    input  logic        cur_secure,
    input  logic        user_only,
    output logic        is_undef,
    output logic        ns_go
);
    logic form_hit;
    logic low_bad;
    logic ns_sel;
    logic link;
    logic sec_ok;

    assign form_hit = (insn[15:8] == 8'h47);
    assign link     = insn[7];
    assign ns_sel   = insn[2];
    assign low_bad  = |insn[1:0];

    generate
        if (SEC_EXT) begin : g_sec
            assign sec_ok = cur_secure & ~user_only;
        end else begin : g_nosec
            assign sec_ok = 1'b0;
        end
    endgenerate

    assign is_undef = in_valid & form_hit & (low_bad | (ns_sel & (link | ~sec_ok)));
    assign ns_go    = in_valid & form_hit & ~low_bad & ns_sel & ~link & sec_ok;
endmodule

// File: rtl/sbx_classify.sv
module sbx_classify #(
    parameter int          AW         = 32,
    parameter logic [31:0] MAGIC_BASE = 32'hFF00_0000
) (
    input  logic [AW-1:0] target,
    output logic          is_magic,
    output logic [AW-1:0] pc_clean,
    output logic          lsb
);
    assign is_magic = (target >= AW'(MAGIC_BASE));
    assign pc_clean = {target[AW-1:1], 1'b0};
    assign lsb      = target[0];
endmodule

// File: rtl/sbx_resolve.sv
module sbx_resolve
    import sbx_pkg::*;
#(
    parameter bit          SEC_EXT    = 1'b1,
    parameter logic [31:0] MAGIC_BASE = 32'hFF00_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [15:0]       insn,
    input  logic [ADDR_W-1:0] target,
    input  logic              cur_secure,
    input  logic              user_only,
    output logic              out_valid,
    output logic [ADDR_W-1:0] new_pc,
    output logic              isa_bit,
    output logic              undef_flag,
    output logic              excret_req,
    output logic              sw_req,
    output logic              sw_secure,
    output logic              cond_clr
);
    sbx_state_t        st_d, st_q;
    logic              dec_undef, dec_go;
    logic              tgt_magic, tgt_lsb;
    logic [ADDR_W-1:0] tgt_pc;

    sbx_decode #(.SEC_EXT(SEC_EXT)) u_dec (
        .in_valid  (in_valid),
        .insn      (insn),
        .cur_secure(cur_secure),
        .user_only (user_only),
        .is_undef  (dec_undef),
        .ns_go     (dec_go)
    );

    sbx_classify #(.AW(ADDR_W), .MAGIC_BASE(MAGIC_BASE)) u_cls (
        .target  (target),
        .is_magic(tgt_magic),
        .pc_clean(tgt_pc),
        .lsb     (tgt_lsb)
    );

    always_comb begin
        st_d        = st_q;
        st_d.vld    = in_valid;
        st_d.undef  = dec_undef;
        st_d.excret = 1'b0;
        st_d.sw     = 1'b0;
        st_d.cclr   = dec_go;
        if (dec_go) begin
            st_d.pc = tgt_pc;
            if (tgt_magic) begin
                st_d.isa    = tgt_lsb;
                st_d.excret = 1'b1;
            end else begin
                st_d.isa    = 1'b1;
                st_d.sw     = 1'b1;
                st_d.sw_sec = tgt_lsb;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.vld;
    assign new_pc     = st_q.pc;
    assign isa_bit    = st_q.isa;
    assign undef_flag = st_q.undef;
    assign excret_req = st_q.excret;
    assign sw_req     = st_q.sw;
    assign sw_secure  = st_q.sw_sec;
    assign cond_clr   = st_q.cclr;
endmodule

// File: rtl/sbx_resolve_chk.sv
module sbx_resolve_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [15:0] insn,
    input logic [31:0] target,
    input logic        cur_secure,
    input logic        out_valid,
    input logic [31:0] new_pc,
    input logic        isa_bit,
    input logic        undef_flag,
    input logic        excret_req,
    input logic        sw_req,
    input logic        sw_secure,
    input logic        cond_clr
);
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({undef_flag, excret_req, sw_req}));

    a_r4_undef_hold: assert property (@(posedge clk) disable iff (!rst_n)
        undef_flag |-> ($stable(new_pc) && $stable(isa_bit) && $stable(sw_secure)));

    a_r6_switch_state: assert property (@(posedge clk) disable iff (!rst_n)
        sw_req |-> (isa_bit && !new_pc[0]));

    a_r5_magic_range: assert property (@(posedge clk) disable iff (!rst_n)
        excret_req |-> (new_pc >= 32'hFEFF_FFFF && !new_pc[0]));

    a_r7_cond_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cond_clr |-> (excret_req || sw_req));

    a_r8_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !(out_valid || undef_flag || excret_req || sw_req || cond_clr));

    a_r3_nonsecure_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && insn[15:8] == 8'h47 && insn[2] && !cur_secure) |=> undef_flag);

    a_r2_low_bits_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && insn[15:8] == 8'h47 && insn[1:0] != 2'b00) |=> undef_flag);
endmodule

bind sbx_resolve sbx_resolve_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .insn      (insn),
    .target    (target),
    .cur_secure(cur_secure),
    .out_valid (out_valid),
    .new_pc    (new_pc),
    .isa_bit   (isa_bit),
    .undef_flag(undef_flag),
    .excret_req(excret_req),
    .sw_req    (sw_req),
    .sw_secure (sw_secure),
    .cond_clr  (cond_clr)
);

// File: tb/tb_sbx_resolve.sv
module tb_sbx_resolve;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] insn = '0;
    logic [31:0] target = '0;
    logic        cur_secure = 1'b0;
    logic        user_only = 1'b0;
    logic        out_valid, isa_bit, undef_flag, excret_req, sw_req, sw_secure, cond_clr;
    logic [31:0] new_pc;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    // reference model state
    logic [31:0] m_pc = '0;
    logic        m_isa = 1'b0, m_swsec = 1'b0;
    logic        m_vld = 1'b0, m_und = 1'b0, m_exc = 1'b0, m_sw = 1'b0, m_cc = 1'b0;
    string       m_tag = "R10";

    always #2 clk = ~clk;

    sbx_resolve dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn), .target(target),
        .cur_secure(cur_secure), .user_only(user_only), .out_valid(out_valid),
        .new_pc(new_pc), .isa_bit(isa_bit), .undef_flag(undef_flag),
        .excret_req(excret_req), .sw_req(sw_req), .sw_secure(sw_secure), .cond_clr(cond_clr)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // behavioural reference for one strobe
    task automatic model(input logic v, input logic [15:0] i, input logic [31:0] t,
                         input logic s, input logic u);
        bit legal_ns;
        m_vld = v; m_und = 0; m_exc = 0; m_sw = 0; m_cc = 0;
        m_tag = "R8";
        if (!v) return;
        if (i[15:8] != 8'h47 || i[2:0] == 3'b000) begin
            m_tag = "R1";
            return;
        end
        if (i[1:0] != 0) begin
            m_und = 1; m_tag = "R2";
            return;
        end
        legal_ns = s && !u && !i[7];
        if (!legal_ns) begin
            m_und = 1; m_tag = "R3";
            return;
        end
        m_cc = 1;
        m_pc = t & 32'hFFFF_FFFE;
        if (t >= 32'hFF00_0000) begin
            m_exc = 1; m_isa = t[0]; m_tag = "R5";
        end else begin
            m_sw = 1; m_isa = 1; m_swsec = t[0]; m_tag = "R6";
        end
    endtask

    task automatic compare();
        string htag;
        htag = m_und ? "R4" : m_tag;
        chk("R8", "out_valid", 32'(out_valid), 32'(m_vld));
        chk(htag, "new_pc", new_pc, m_pc);
        chk(htag, "isa_bit", 32'(isa_bit), 32'(m_isa));
        chk(htag, "sw_secure", 32'(sw_secure), 32'(m_swsec));
        chk(m_tag, "undef_flag", 32'(undef_flag), 32'(m_und));
        chk(m_tag, "excret_req", 32'(excret_req), 32'(m_exc));
        chk(m_tag, "sw_req", 32'(sw_req), 32'(m_sw));
        chk("R7", "cond_clr", 32'(cond_clr), 32'(m_cc));
        chk("R9", "exclusive", 32'($countones({undef_flag, excret_req, sw_req}) <= 1), 32'd1);
    endtask

    task automatic step(input logic v, input logic [15:0] i, input logic [31:0] t,
                        input logic s, input logic u);
        @(negedge clk);
        in_valid = v; insn = i; target = t; cur_secure = s; user_only = u;
        model(v, i, t, s, u);
        @(negedge clk);
        in_valid = 0;
        compare();
    endtask

    function automatic logic [15:0] ns_op(input logic [3:0] rm, input logic lnk);
        return 16'h4704 | (16'(lnk) << 7) | (16'(rm) << 3);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 50000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10", "new_pc", new_pc, 32'h0);
        chk("R10", "isa_bit", 32'(isa_bit), 32'h0);
        chk("R10", "sw_secure", 32'(sw_secure), 32'h0);
        chk("R10", "pulses", 32'({out_valid, undef_flag, excret_req, sw_req, cond_clr}), 32'h0);
        rst_n = 1'b1;
        step(0, ns_op(4'd1, 0), 32'h1000_0000, 1, 0);       // R8 no strobe
        step(1, ns_op(4'd2, 0), 32'h0000_2468, 1, 0);       // R6 switch to non-secure
        step(1, ns_op(4'd3, 0), 32'h0800_1235, 1, 0);       // R6 stay secure
        step(1, ns_op(4'd4, 0), 32'hFFFF_FFFD, 1, 0);       // R5 magic
        step(1, ns_op(4'd5, 0), 32'hFF00_0000, 1, 0);       // R5 boundary
        step(1, ns_op(4'd6, 0), 32'hFEFF_FFFF, 1, 0);       // R6 just below boundary
        step(1, ns_op(4'd7, 0), 32'h1111_1110, 0, 0);       // R3 non-secure
        step(1, ns_op(4'd7, 0), 32'h2222_2220, 1, 1);       // R3 user-only
        step(1, ns_op(4'd7, 1), 32'h3333_3330, 1, 0);       // R3 link
        step(1, 16'h4705, 32'h4444_4444, 1, 0);             // R2 low bits
        step(1, 16'h4702, 32'h5555_5554, 1, 0);             // R2 low bits
        step(1, 16'h4710, 32'h6666_6666, 1, 0);             // R1 plain form
        step(1, 16'h4604, 32'h7777_7776, 1, 0);             // R1 foreign opcode
        step(1, ns_op(4'd9, 0), 32'hFF12_3450, 1, 0);       // R5 magic with bit0 clear
        for (int k = 0; k < 300; k++) begin
            logic [15:0] op;
            logic [31:0] tg;
            op = ($urandom % 2) ? ns_op(4'($urandom), 1'($urandom % 4 == 0)) : 16'($urandom);
            if ($urandom % 3 == 0) op[1:0] = 2'($urandom);
            tg = ($urandom % 4 == 0) ? (32'hFF00_0000 | 32'($urandom % 256)) : 32'($urandom);
            step(1'($urandom % 5 != 0), op, tg, 1'($urandom % 4 != 0), 1'($urandom % 6 == 0));
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule